// File: doc/BRIEF.md
# Interleaved Six-Channel Frame Sampler

The block is a timed acquisition sequencer. It runs in fixed frames whose length is counted in system clock cycles. In every frame it starts one conversion on each analog channel in a fixed order, through a start/busy/data handshake with an external converter. Each 16-bit result goes to one shared output stream, so a downstream FIFO receives the channels interleaved: channel 0, 1, … 5, then channel 0 of the next frame, and so on. The timing is deterministic. A frame always lasts the configured number of cycles, and conversion k of a frame starts a fixed number of cycles after the frame begins. Frame timing never depends on the converter or on the consumer.

The output is a valid/ready stream with no back-pressure. A word is offered for exactly one cycle and is never held. If `out_ready` is low in that cycle, the word is lost and the sticky `ovf` flag is raised. The sequencer then skips the rest of that frame, so the next word written is always a channel 0 and the alignment of the stream is kept. Acquisition begins only on a frame boundary when `en` is high. When `en` falls, the frame in progress runs to its end.

A 700 µs frame at a 50 MHz clock corresponds to `cfg_period` = 35000. A spacing of 8 µs between conversions corresponds to `GAP` = 400.

Top module: `ileave_sampler`

## Requirements
- R1: Each frame issues at most `CH_N` conversion starts (`adc_start` high for one cycle), with `adc_ch` taking the values 0, 1, … `CH_N`-1 in that order. No start carries a channel number of `CH_N` or above.
- R2: Within a frame, consecutive starts are exactly `GAP` cycles apart. No two starts, even across a frame boundary, are fewer than `GAP` cycles apart.
- R3: The distance between the channel-0 starts of back-to-back frames equals the effective period. The effective period is `cfg_period`, raised to `CH_N`*`GAP` when `cfg_period` is smaller.
- R4: When `adc_busy` falls after a start, `out_valid` is high for exactly the next cycle, and `out_data` carries the `adc_data` value present in the cycle the busy fell. Every word of a frame is written before the next frame's first start.
- R5: A word offered while `out_ready` is low is lost and sets `ovf`. No further start or word occurs in that frame. The next word accepted is channel 0 of the following frame.
- R6: `ovf` stays high until a cycle with `ovf_clr` high clears it. A loss in the same cycle as a clear wins.
- R7: With `en` high, frames start at a frame boundary. When `en` goes low, the frame in progress completes all of its conversions and words, and no further start follows.
- R8: After reset, `adc_start`, `out_valid` and `ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Acquisition enable, sampled at frame boundaries |
| cfg_period | input | PERIOD_W | Frame length in clock cycles, clamped to at least CH_N*GAP |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_ch | output | $clog2(CH_N) | Channel selected for the starting conversion |
| adc_busy | input | 1 | Converter busy; its falling edge marks data ready |
| adc_data | input | SAMPLE_W | Conversion result, valid when busy falls |
| out_valid | output | 1 | Output word offered (single cycle, never held) |
| out_ready | input | 1 | Consumer can take a word (low means FIFO full) |
| out_data | output | SAMPLE_W | Output sample word |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| ovf | output | 1 | Sticky flag: a word was lost |

## Verification
The assertions rely on a converter that raises `adc_busy` in the cycle after a start and lowers it no more than `GAP`-4 cycles later. They also assume the converter never raises busy without a start. Under those conditions the one-cycle write that follows each falling edge lands inside its own frame. The bench's converter stub follows this rule: it stays busy for four cycles against a spacing of ten, and each result is tagged with its channel and a frame count. The bench changes `out_ready` and `en` only on falling clock edges, at moments derived from the starts it has already observed. This makes each loss and each stop fall at a known point in a frame.

// File: rtl/ileave_pkg.sv
package ileave_pkg;

  // Shortest legal frame: every channel slot must fit.
  function automatic int unsigned floor_period(int unsigned ch_n, int unsigned gap);
    return ch_n * gap;
  endfunction

endpackage

// File: rtl/ileave_frame_timer.sv
module ileave_frame_timer #(
  parameter int unsigned CH_N     = 6,
  parameter int unsigned GAP      = 400,
  parameter int unsigned PERIOD_W = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [PERIOD_W-1:0] cfg_period,
  output logic                frame_go
);
  import ileave_pkg::*;

  localparam logic [PERIOD_W-1:0] MIN_LEN = PERIOD_W'(floor_period(CH_N, GAP));

  logic                running;
  logic [PERIOD_W-1:0] fcnt;
  logic [PERIOD_W-1:0] flen;
  logic [PERIOD_W-1:0] eff_len;

  always_comb eff_len = (cfg_period < MIN_LEN) ? MIN_LEN : cfg_period;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      fcnt    <= '0;
      flen    <= MIN_LEN;
    end else if (!running) begin
      if (en) begin
        running <= 1'b1;
        fcnt    <= '0;
        flen    <= eff_len;
      end
    end else if (fcnt == flen - PERIOD_W'(1)) begin
      fcnt    <= '0;
      flen    <= eff_len;
      running <= en;
    end else begin
      fcnt <= fcnt + PERIOD_W'(1);
    end
  end

  assign frame_go = running && (fcnt == '0);

endmodule

// File: rtl/ileave_slot_sched.sv
module ileave_slot_sched #(
  parameter int unsigned CH_N = 6,
  parameter int unsigned GAP  = 400
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      frame_go,
  input  logic                      drop,
  output logic                      conv_start,
  output logic [$clog2(CH_N)-1:0]   conv_ch
);
  localparam int unsigned SW = $clog2(CH_N + 1);
  localparam int unsigned GW = $clog2(GAP + 1);
  localparam int unsigned CW = $clog2(CH_N);

  logic [SW-1:0] slot;
  logic [GW-1:0] gcnt;
  logic          slots_left;

  always_comb slots_left = (slot < SW'(CH_N));

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= SW'(CH_N);
      gcnt <= '0;
    end else if (frame_go) begin
      slot <= '0;
      gcnt <= '0;
    end else if (slots_left) begin
      if (gcnt == GW'(GAP - 1)) begin
        gcnt <= '0;
        slot <= slot + SW'(1);
      end else begin
        gcnt <= gcnt + GW'(1);
      end
    end
  end

  assign conv_start = slots_left && (gcnt == '0) && !drop;
  assign conv_ch    = slot[CW-1:0];

endmodule

// File: rtl/ileave_capture.sv
module ileave_capture #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_go,
  input  logic                adc_busy,
  input  logic [SAMPLE_W-1:0] adc_data,
  input  logic                out_ready,
  input  logic                ovf_clr,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                ovf,
  output logic                drop
);
  logic busy_q;
  logic conv_done;
  logic lost;

  always_comb conv_done = busy_q && !adc_busy;
  always_comb lost      = out_valid && !out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      ovf       <= 1'b0;
      drop      <= 1'b0;
    end else begin
      busy_q    <= adc_busy;
      out_valid <= conv_done;
      if (conv_done) out_data <= adc_data;
      if (lost)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
      if (frame_go)  drop <= 1'b0;
      else if (lost) drop <= 1'b1;
    end
  end

endmodule

// File: rtl/ileave_sampler.sv
module ileave_sampler #(
  parameter int unsigned CH_N     = 6,
  parameter int unsigned GAP      = 400,
  parameter int unsigned PERIOD_W = 20,
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [PERIOD_W-1:0]     cfg_period,
  output logic                    adc_start,
  output logic [$clog2(CH_N)-1:0] adc_ch,
  input  logic                    adc_busy,
  input  logic [SAMPLE_W-1:0]     adc_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [SAMPLE_W-1:0]     out_data,
  input  logic                    ovf_clr,
  output logic                    ovf
);
  logic frame_go;
  logic drop;

  ileave_frame_timer #(.CH_N(CH_N), .GAP(GAP), .PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst(rst), .en(en), .cfg_period(cfg_period), .frame_go(frame_go)
  );

  ileave_slot_sched #(.CH_N(CH_N), .GAP(GAP)) u_sched (
    .clk(clk), .rst(rst), .frame_go(frame_go), .drop(drop),
    .conv_start(adc_start), .conv_ch(adc_ch)
  );

  ileave_capture #(.SAMPLE_W(SAMPLE_W)) u_cap (
    .clk(clk), .rst(rst), .frame_go(frame_go), .adc_busy(adc_busy),
    .adc_data(adc_data), .out_ready(out_ready), .ovf_clr(ovf_clr),
    .out_valid(out_valid), .out_data(out_data), .ovf(ovf), .drop(drop)
  );

endmodule

// File: rtl/ileave_sampler_chk.sv
module ileave_sampler_chk #(
  parameter int unsigned CH_N     = 6,
  parameter int unsigned GAP      = 400,
  parameter int unsigned SAMPLE_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    adc_start,
  input logic [$clog2(CH_N)-1:0] adc_ch,
  input logic                    adc_busy,
  input logic [SAMPLE_W-1:0]     adc_data,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [SAMPLE_W-1:0]     out_data,
  input logic                    ovf_clr,
  input logic                    ovf
);
  localparam int unsigned GW = $clog2(GAP + 1);
  localparam int unsigned CW = $clog2(CH_N);

  logic [GW-1:0] since;
  logic          lost_seen;
  logic [CW-1:0] last_ch;

  always_ff @(posedge clk) begin
    if (rst) begin
      since     <= GW'(GAP);
      lost_seen <= 1'b0;
      last_ch   <= '0;
    end else begin
      if (adc_start)               since <= GW'(1);
      else if (since < GW'(GAP))   since <= since + GW'(1);
      if (out_valid && !out_ready)          lost_seen <= 1'b1;
      else if (adc_start && adc_ch == '0)   lost_seen <= 1'b0;
      if (adc_start) last_ch <= adc_ch;
    end
  end

  // R1
  a_r1_ch_range: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> (int'(adc_ch) < CH_N));
  // R1
  a_r1_ch_order: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> (adc_ch == '0 || adc_ch == last_ch + CW'(1)));
  // R2
  a_r2_min_spacing: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> (since >= GW'(GAP)));
  // R4
  a_r4_word_follows_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_busy) |=> (out_valid && out_data == $past(adc_data)));
  // R4
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R5
  a_r5_loss_flags: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> ovf);
  // R5
  a_r5_frame_skipped: assert property (@(posedge clk) disable iff (rst)
    (adc_start && lost_seen) |-> (adc_ch == '0));
  // R6
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);
  // R6
  a_r6_ovf_clear: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !(out_valid && !out_ready)) |=> !ovf);

endmodule

bind ileave_sampler ileave_sampler_chk #(.CH_N(CH_N), .GAP(GAP), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .adc_start(adc_start), .adc_ch(adc_ch), .adc_busy(adc_busy),
  .adc_data(adc_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .ovf_clr(ovf_clr), .ovf(ovf)
);

// File: tb/ileave_sampler_bench.sv
module ileave_sampler_bench;
  localparam int unsigned CH_N = 6;
  localparam int unsigned GAP  = 10;
  localparam int unsigned PW   = 20;
  localparam int unsigned SW   = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic [PW-1:0] cfg_period = PW'(100);
  logic          adc_start;
  logic [2:0]    adc_ch;
  logic          adc_busy;
  logic [SW-1:0] adc_data;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [SW-1:0] out_data;
  logic          ovf_clr = 1'b0;
  logic          ovf;

  always #10 clk = ~clk;

  ileave_sampler #(.CH_N(CH_N), .GAP(GAP), .PERIOD_W(PW), .SAMPLE_W(SW)) u_ileave_sampler (
    .clk(clk), .rst(rst), .en(en), .cfg_period(cfg_period), .adc_start(adc_start),
    .adc_ch(adc_ch), .adc_busy(adc_busy), .adc_data(adc_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .ovf_clr(ovf_clr), .ovf(ovf)
  );

  // Converter stub: busy for 4 cycles, result tagged {channel, frame count}.
  logic [2:0]  stub_cnt;
  logic [2:0]  stub_ch;
  logic [11:0] stub_fr;
  always_ff @(posedge clk) begin
    if (rst) begin
      adc_busy <= 1'b0; stub_cnt <= '0; stub_ch <= '0; stub_fr <= '0; adc_data <= '0;
    end else if (adc_start) begin
      adc_busy <= 1'b1; stub_cnt <= 3'd3; stub_ch <= adc_ch;
      if (adc_ch == 3'd0) stub_fr <= stub_fr + 12'd1;
    end else if (adc_busy) begin
      if (stub_cnt == 3'd0) begin
        adc_busy <= 1'b0;
        adc_data <= {1'b0, stub_ch, stub_fr};
      end else stub_cnt <= stub_cnt - 3'd1;
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int st_t[$];
  int st_c[$];
  logic [SW-1:0] words[$];
  int n_valid = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (adc_start) begin st_t.push_back(cyc); st_c.push_back(int'(adc_ch)); end
      if (out_valid) begin
        n_valid++;
        if (out_ready) words.push_back(out_data);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    st_t.delete(); st_c.delete(); words.delete(); n_valid = 0;
  endtask

  task automatic wait_starts(input int n);
    while (st_t.size() < n) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // words must match channel list exp_c with frame offsets exp_f from the first word
  task automatic check_words(input int exp_c[$], input int exp_f[$], input string req);
    int base;
    chk(words.size() == exp_c.size(), req, words.size(), exp_c.size());
    if (words.size() == 0) return;
    base = int'(words[0][11:0]);
    for (int i = 0; i < words.size() && i < exp_c.size(); i++) begin
      chk(int'(words[i][14:12]) == exp_c[i], req, int'(words[i][14:12]), exp_c[i]);
      chk(int'(words[i][11:0]) == base + exp_f[i], req, int'(words[i][11:0]), base + exp_f[i]);
    end
  endtask

  task automatic t_reset();
    idle(1);
    chk(adc_start == 1'b0, "R8", int'(adc_start), 0);
    chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
    chk(ovf == 1'b0, "R8", int'(ovf), 0);
  endtask

  task automatic t_basic();
    int ec[$]; int ef[$];
    clear_logs();
    cfg_period = PW'(100);
    en = 1'b1;
    wait_starts(18);
    en = 1'b0;
    idle(300);
    chk(st_t.size() == 18, "R7", st_t.size(), 18);
    for (int i = 0; i < 18; i++) begin
      ec.push_back(i % 6); ef.push_back(i / 6);
      if (i < st_t.size()) begin
        chk(st_c[i] == i % 6, "R1", st_c[i], i % 6);
        if (i % 6 != 0) chk(st_t[i] - st_t[i-1] == GAP, "R2", st_t[i] - st_t[i-1], GAP);
        else if (i > 0) chk(st_t[i] - st_t[i-6] == 100, "R3", st_t[i] - st_t[i-6], 100);
      end
    end
    chk(n_valid == 18, "R4", n_valid, 18);
    check_words(ec, ef, "R4");
    chk(ovf == 1'b0, "R5", int'(ovf), 0);
  endtask

  task automatic t_clamp();
    clear_logs();
    cfg_period = PW'(20);  // below 6*GAP: effective 60
    en = 1'b1;
    wait_starts(12);
    en = 1'b0;
    idle(200);
    chk(st_t.size() == 12, "R3", st_t.size(), 12);
    if (st_t.size() >= 7) chk(st_t[6] - st_t[0] == 60, "R3", st_t[6] - st_t[0], 60);
    if (st_t.size() >= 12) chk(st_t[11] - st_t[10] == GAP, "R2", st_t[11] - st_t[10], GAP);
  endtask

  task automatic t_stop_mid();
    int ec[$]; int ef[$];
    clear_logs();
    cfg_period = PW'(100);
    en = 1'b1;
    wait_starts(3);
    en = 1'b0;
    idle(300);
    chk(st_t.size() == 6, "R7", st_t.size(), 6);
    for (int i = 0; i < 6; i++) begin ec.push_back(i); ef.push_back(0); end
    check_words(ec, ef, "R7");
  endtask

  task automatic t_overflow();
    int ec[$]; int ef[$];
    clear_logs();
    cfg_period = PW'(100);
    en = 1'b1;
    wait_starts(9);        // frame 2, channel 2 just started
    out_ready = 1'b0;      // its word (5 cycles on) is refused
    idle(20);
    out_ready = 1'b1;
    wait_starts(15);
    en = 1'b0;
    idle(300);
    chk(st_t.size() == 15, "R5", st_t.size(), 15);
    chk(n_valid == 15, "R5", n_valid, 15);
    chk(ovf == 1'b1, "R5", int'(ovf), 1);
    for (int i = 0; i < 6; i++) begin ec.push_back(i); ef.push_back(0); end
    for (int i = 0; i < 2; i++) begin ec.push_back(i); ef.push_back(1); end
    for (int i = 0; i < 6; i++) begin ec.push_back(i); ef.push_back(2); end
    check_words(ec, ef, "R5");
    idle(50);
    chk(ovf == 1'b1, "R6", int'(ovf), 1);
    ovf_clr = 1'b1;
    idle(1);
    ovf_clr = 1'b0;
    chk(ovf == 1'b0, "R6", int'(ovf), 0);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_clamp();
    t_stop_mid();
    t_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule